// File: doc/BRIEF.md
# SPI Chip-Select Hold Controller

This block owns the chip-select lines of a master SPI port. Each transfer request carries a target line number and a hold flag. The controller drives the selected line low and signals the shift engine to begin. When the engine reports the end of the transfer, the controller does one of two things: it keeps the line low because hold was requested, or it releases the line after a programmable transfer-to-release delay.

Releases follow two rules. A line that was just released stays high for a minimum number of cycles before the same target can be selected again. A different target can be selected on the next cycle. A held line carries straight on into the next transfer only when that transfer targets the same line. If the target changes, the held line is released first, and the new line is driven low one clock later.

Requests that carry only control information and no data word start nothing and leave every line alone. The hold flag has effect only when the port is in master mode.

Top module: `cs_hold_ctrl`

## Requirements
- R1: After reset every chip-select output is high (inactive), `xfer_go` is low and `req_ready` is high.
- R2: A write with `ctrl_has_data`=1 accepted at clock edge P drives `cs_n[ctrl_cs]` low at edge P+1, and `xfer_go` is high for exactly the cycle after edge P+1. Bit i of `cs_n` belongs to line number i.
- R3: Without an effective hold, the line rises at edge E+1+D. E is the edge that samples `xfer_end`, and D is `t2c_delay`. With D=0 the line rises on the next edge.
- R4: After a line is released, a queued request for the same line waits so that the line stays high for at least MIN_GAP (default 2) cycles.
- R5: A queued request for a different line is not delayed by the gap. It asserts on the edge after the release.
- R6: In master mode, with the hold flag set, the line stays low after `xfer_end` until a new data request arrives.
- R7: A data request for the same line as a held line starts with no gap. The line never goes high, and `xfer_go` pulses on the edge after the request is accepted.
- R8: A data request for a different line than the held one releases the held line on the edge after acceptance. The new line asserts one edge later, so no two lines ever change in the same cycle.
- R9: In slave mode (`master_mode`=0) the hold flag is ignored and R3 applies. Leaving master mode while a line is held releases it on the next edge.
- R10: A write with `ctrl_has_data`=0 changes neither `cs_n` nor `xfer_go` and leaves `req_ready` high.
- R11: At most one chip-select line is low at any time, and `xfer_go` is only high while a line is low.
- R12: `req_ready` is low while an accepted request has not yet started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1 = master mode (hold honoured), 0 = slave mode |
| t2c_delay | input | DLY_W | Transfer-end to release delay in cycles |
| ctrl_wr | input | 1 | Control/data write strobe |
| ctrl_has_data | input | 1 | Write carries a data word (starts a transfer) |
| ctrl_cs | input | CS_W | Target chip-select number |
| ctrl_hold | input | 1 | Keep the line low after this transfer |
| req_ready | output | 1 | Request slot is empty |
| xfer_go | output | 1 | One-cycle pulse: transfer may begin |
| xfer_end | input | 1 | Shift engine reports the end of the transfer |
| cs_n | output | NUM_CS | Active-low chip-select lines |

## Verification
A phase register stuck in the wrong state shows at the ports in one of three ways: a line rises early or late relative to the `xfer_end` edge plus `t2c_delay`, a held line rises between transfers, or a `xfer_go` pulse is missing or arrives late. Each of these is visible within one or two cycles of the event that should have caused the change. A corrupted gap timer shows as a same-line re-assertion one cycle early, or as a different-line request that is delayed needlessly. A mishandled control-only write shows at once as a spurious `xfer_go` or a lowered `req_ready`.

// File: rtl/cs_hold_pkg.sv
package cs_hold_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BUSY,
        PH_LINGER,
        PH_KEEP
    } phase_e;
endpackage

// File: rtl/cs_hold_slot.sv
module cs_hold_slot #(
    parameter int CS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CS_W-1:0] sel_in,
    input  logic            keep_in,
    input  logic            take,
    output logic            full,
    output logic [CS_W-1:0] sel,
    output logic            keep
);
    typedef struct packed {
        logic            full;
        logic [CS_W-1:0] sel;
        logic            keep;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (take) begin
            slot_d.full = 1'b0;
        end
        if (load && !slot_q.full) begin
            slot_d.full = 1'b1;
            slot_d.sel  = sel_in;
            slot_d.keep = keep_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign full = slot_q.full;
    assign sel  = slot_q.sel;
    assign keep = slot_q.keep;
endmodule

// File: rtl/cs_hold_gap.sv
module cs_hold_gap #(
    parameter int CS_W    = 2,
    parameter int MIN_GAP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            release_i,
    input  logic [CS_W-1:0] release_cs,
    input  logic [CS_W-1:0] probe_cs,
    output logic            probe_ok
);
    localparam int CNT_W = (MIN_GAP > 1) ? $clog2(MIN_GAP + 1) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(MIN_GAP - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CS_W-1:0]  last;
    } gap_t;

    gap_t gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (gap_q.cnt != '0) begin
            gap_d.cnt = gap_q.cnt - 1'b1;
        end
        if (release_i) begin
            gap_d.cnt  = LOAD;
            gap_d.last = release_cs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_d;
        end
    end

    assign probe_ok = !((gap_q.cnt != '0) && (probe_cs == gap_q.last));
endmodule

// File: rtl/cs_hold_decode.sv
module cs_hold_decode #(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2
) (
    input  logic              on,
    input  logic [CS_W-1:0]   sel,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign cs_n[i] = !(on && (sel == CS_W'(i)));
    end
endmodule

// File: rtl/cs_hold_ctrl.sv
module cs_hold_ctrl
    import cs_hold_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int DLY_W   = 8,
    parameter int MIN_GAP = 2,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic [DLY_W-1:0]  t2c_delay,
    input  logic              ctrl_wr,
    input  logic              ctrl_has_data,
    input  logic [CS_W-1:0]   ctrl_cs,
    input  logic              ctrl_hold,
    output logic              req_ready,
    output logic              xfer_go,
    input  logic              xfer_end,
    output logic [NUM_CS-1:0] cs_n
);
    typedef struct packed {
        phase_e           ph;
        logic [CS_W-1:0]  cur;
        logic             hold;
        logic             on;
        logic             go;
        logic [DLY_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            pend_full;
    logic [CS_W-1:0] pend_cs;
    logic            pend_hold;
    logic            take;
    logic            rel;
    logic            gap_ok;
    logic            load;

    assign load = ctrl_wr && ctrl_has_data;

    cs_hold_slot #(.CS_W(CS_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .sel_in  (ctrl_cs),
        .keep_in (ctrl_hold),
        .take    (take),
        .full    (pend_full),
        .sel     (pend_cs),
        .keep    (pend_hold)
    );

    cs_hold_gap #(.CS_W(CS_W), .MIN_GAP(MIN_GAP)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .release_i  (rel),
        .release_cs (ctl_q.cur),
        .probe_cs   (pend_cs),
        .probe_ok   (gap_ok)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.go = 1'b0;
        take     = 1'b0;
        rel      = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (pend_full && gap_ok) begin
                    take       = 1'b1;
                    ctl_d.cur  = pend_cs;
                    ctl_d.hold = pend_hold;
                    ctl_d.on   = 1'b1;
                    ctl_d.go   = 1'b1;
                    ctl_d.ph   = PH_BUSY;
                end
            end
            PH_BUSY: begin
                if (xfer_end) begin
                    if (ctl_q.hold && master_mode) begin
                        ctl_d.ph = PH_KEEP;
                    end else begin
                        ctl_d.cnt = t2c_delay;
                        ctl_d.ph  = PH_LINGER;
                    end
                end
            end
            PH_LINGER: begin
                if (ctl_q.cnt == '0) begin
                    rel      = 1'b1;
                    ctl_d.on = 1'b0;
                    ctl_d.ph = PH_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_KEEP: begin
                if (!master_mode) begin
                    rel      = 1'b1;
                    ctl_d.on = 1'b0;
                    ctl_d.ph = PH_IDLE;
                end else if (pend_full) begin
                    if (pend_cs == ctl_q.cur) begin
                        take       = 1'b1;
                        ctl_d.hold = pend_hold;
                        ctl_d.go   = 1'b1;
                        ctl_d.ph   = PH_BUSY;
                    end else begin
                        rel      = 1'b1;
                        ctl_d.on = 1'b0;
                        ctl_d.ph = PH_IDLE;
                    end
                end
            end
            default: begin
                ctl_d.ph = PH_IDLE;
                ctl_d.on = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, cur: '0, hold: 1'b0, on: 1'b0, go: 1'b0, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    cs_hold_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dec (
        .on   (ctl_q.on),
        .sel  (ctl_q.cur),
        .cs_n (cs_n)
    );

    assign xfer_go   = ctl_q.go;
    assign req_ready = !pend_full;
endmodule

// File: rtl/cs_hold_ctrl_chk.sv
module cs_hold_ctrl_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic              ctrl_has_data,
    input logic              req_ready,
    input logic              xfer_go,
    input logic [NUM_CS-1:0] cs_n
);
    assert_one_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    assert_go_needs_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |-> (cs_n != '1));

    assert_switch_through_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_n != '1) && ($past(cs_n) != '1)) |-> (cs_n == $past(cs_n)));

    assert_ctrl_only_keeps_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_has_data && req_ready) |=> req_ready);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_gap
        assert_min_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cs_n[i]) |=> cs_n[i]);
    end
endmodule

bind cs_hold_ctrl cs_hold_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_wr       (ctrl_wr),
    .ctrl_has_data (ctrl_has_data),
    .req_ready     (req_ready),
    .xfer_go       (xfer_go),
    .cs_n          (cs_n)
);

// File: tb/cs_hold_ctrl_tb.sv
`timescale 1ns/1ps
module cs_hold_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_mode = 1'b1;
    logic [7:0] t2c_delay = '0;
    logic       ctrl_wr = 1'b0;
    logic       ctrl_has_data = 1'b0;
    logic [1:0] ctrl_cs = '0;
    logic       ctrl_hold = 1'b0;
    logic       req_ready;
    logic       xfer_go;
    logic       xfer_end = 1'b0;
    logic [3:0] cs_n;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;

    typedef struct {
        int         at;
        logic [3:0] csn;
        logic       go;
        string      tag;
    } exp_t;
    exp_t sb[$];

    cs_hold_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .t2c_delay(t2c_delay),
        .ctrl_wr(ctrl_wr), .ctrl_has_data(ctrl_has_data), .ctrl_cs(ctrl_cs),
        .ctrl_hold(ctrl_hold), .req_ready(req_ready), .xfer_go(xfer_go),
        .xfer_end(xfer_end), .cs_n(cs_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [3:0] low(int i);
        return ~(4'b0001 << i);
    endfunction

    task automatic push(int at, logic [3:0] csn, logic go, string tag);
        exp_t e;
        e.at = at; e.csn = csn; e.go = go; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check(bit ok, string tag, string act, string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor: pops expected items as their cycle comes up
    always @(negedge clk) begin
        if (mon_on) begin
            check($countones(~cs_n) <= 1, "R11", $sformatf("cs_n=%b", cs_n), "at most one low");
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(e.at == cyc && cs_n === e.csn && xfer_go === e.go, e.tag,
                      $sformatf("cs_n=%b go=%b cyc=%0d", cs_n, xfer_go, cyc),
                      $sformatf("cs_n=%b go=%b cyc=%0d", e.csn, e.go, e.at));
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic req(int cs, bit hold, output int p);
        ctrl_wr = 1'b1; ctrl_has_data = 1'b1; ctrl_cs = 2'(cs); ctrl_hold = hold;
        tick();
        p = cyc;
        ctrl_wr = 1'b0; ctrl_has_data = 1'b0; ctrl_hold = 1'b0;
    endtask

    task automatic endx(output int e);
        xfer_end = 1'b1;
        tick();
        e = cyc;
        xfer_end = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int p, p2, e, e2, w;
        repeat (3) tick();
        // R1 reset state
        check(cs_n === 4'hF, "R1", $sformatf("%b", cs_n), "1111");
        check(xfer_go === 1'b0, "R1", $sformatf("%b", xfer_go), "0");
        check(req_ready === 1'b1, "R1", $sformatf("%b", req_ready), "1");
        rst_n = 1'b1;
        tick();
        mon_on = 1'b1;

        // R2/R3: plain transfer, delay 3
        t2c_delay = 8'd3;
        req(1, 0, p);
        push(p + 1, low(1), 1, "R2"); push(p + 2, low(1), 0, "R2");
        tick(); tick();
        endx(e);
        push(e + 3, low(1), 0, "R3"); push(e + 4, 4'hF, 0, "R3");
        repeat (8) tick();

        // R3: delay 0
        t2c_delay = 8'd0;
        req(2, 0, p);
        push(p + 1, low(2), 1, "R3");
        tick();
        endx(e);
        push(e + 1, 4'hF, 0, "R3");
        repeat (4) tick();

        // R4/R12: same line queued during transfer
        req(0, 0, p);
        push(p + 1, low(0), 1, "R4");
        tick();
        req(0, 0, p2);
        check(req_ready === 1'b0, "R12", $sformatf("%b", req_ready), "0");
        endx(e);
        push(e + 1, 4'hF, 0, "R4"); push(e + 2, 4'hF, 0, "R4"); push(e + 3, low(0), 1, "R4");
        repeat (4) tick();
        endx(e2);
        push(e2 + 1, 4'hF, 0, "R4");
        repeat (4) tick();

        // R5: different line queued
        req(0, 0, p);
        push(p + 1, low(0), 1, "R5");
        tick();
        req(3, 0, p2);
        endx(e);
        push(e + 1, 4'hF, 0, "R5"); push(e + 2, low(3), 1, "R5");
        repeat (3) tick();
        endx(e2);
        push(e2 + 1, 4'hF, 0, "R5");
        repeat (4) tick();

        // R6/R7: hold then same line
        req(2, 1, p);
        push(p + 1, low(2), 1, "R6");
        tick();
        endx(e);
        push(e + 1, low(2), 0, "R6"); push(e + 4, low(2), 0, "R6");
        repeat (5) tick();
        req(2, 0, w);
        push(w + 1, low(2), 1, "R7");
        tick();
        endx(e2);
        push(e2 + 1, 4'hF, 0, "R7");
        repeat (4) tick();

        // R8: hold then different line
        req(1, 1, p);
        push(p + 1, low(1), 1, "R8");
        tick();
        endx(e);
        repeat (3) tick();
        req(3, 0, w);
        push(w + 1, 4'hF, 0, "R8"); push(w + 2, low(3), 1, "R8");
        tick(); tick();
        endx(e2);
        push(e2 + 1, 4'hF, 0, "R8");
        repeat (4) tick();

        // R9: slave mode ignores hold
        master_mode = 1'b0;
        req(1, 1, p);
        push(p + 1, low(1), 1, "R9");
        tick();
        endx(e);
        push(e + 1, 4'hF, 0, "R9");
        repeat (4) tick();
        // R9: leaving master mode releases a held line
        master_mode = 1'b1;
        req(2, 1, p);
        push(p + 1, low(2), 1, "R9");
        tick();
        endx(e);
        tick(); tick();
        push(cyc + 1, 4'hF, 0, "R9");
        master_mode = 1'b0;
        tick();
        master_mode = 1'b1;
        repeat (4) tick();

        // R10: control-only write while held, then while idle
        req(1, 1, p);
        push(p + 1, low(1), 1, "R10");
        tick();
        endx(e);
        tick();
        ctrl_wr = 1'b1; ctrl_has_data = 1'b0; ctrl_cs = 2'd3;
        push(cyc + 1, low(1), 0, "R10"); push(cyc + 3, low(1), 0, "R10");
        tick();
        ctrl_wr = 1'b0;
        tick(); tick();
        check(req_ready === 1'b1, "R10", $sformatf("%b", req_ready), "1");
        req(1, 0, w);
        push(w + 1, low(1), 1, "R10");
        tick();
        endx(e2);
        push(e2 + 1, 4'hF, 0, "R10");
        repeat (4) tick();
        ctrl_wr = 1'b1; ctrl_has_data = 1'b0; ctrl_cs = 2'd0;
        push(cyc + 1, 4'hF, 0, "R10"); push(cyc + 3, 4'hF, 0, "R10");
        tick();
        ctrl_wr = 1'b0;
        repeat (4) tick();
        check(req_ready === 1'b1, "R10", $sformatf("%b", req_ready), "1");

        while (sb.size() > 0) tick();
        finish_run();
    end
endmodule